// File: doc/BRIEF.md
# I2C Control Register Unit

This block is the software-facing control register of an I2C master/slave peripheral, together with the logic that enables and disables it. Software uses an 8-bit register bus with an address, a write strobe, write data and combinational read data. The block holds six control bits: enable, general-call enable, start request, acknowledge enable, stop request and interrupt enable. It drives these bits to the bit-level bus engine. It also clears the start and stop requests when the engine reports the matching bus event.

The block also holds a small configuration register for the engine. This register has a clock-frequency code and a 10-bit addressing enable. It can be written only while the peripheral is disabled. The peripheral is turned on in two steps. The first write that sets the enable bit changes nothing else. A second write then loads the other bits. Turning the peripheral off clears every control bit except the stop request.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, the control register reads 00h, the configuration register reads 00h, every control output is 0 and irq_pulse is 0.
- R2: A write to the control address (CTL_ADDR, default 0) while disabled copies only bit 5 of the write data into the enable bit. All other written bits are ignored and those register bits keep their values.
- R3: A write to the control address while enabled, with bit 5 set, loads the control bits from the write data: bit 4 general call, bit 3 start, bit 2 acknowledge, bit 1 stop, bit 0 interrupt enable. The rule in R9 still applies to the stop bit.
- R4: A write to the control address while enabled, with bit 5 clear, clears enable, general call, start, acknowledge and interrupt enable. The stop bit keeps its earlier value.
- R5: Reading the control address returns {2'b00, enable, general call, start, acknowledge, stop, interrupt enable}. Reading the configuration address (CFG_ADDR, default 1) returns {4'b0000, addr10, freq[2:0]}. Reading any other address returns 00h.
- R6: When ev_start_sent is 1 at a clock edge, the start bit is 0 after that edge, even if a write in the same cycle sets it.
- R7: irq_pulse is 1 for exactly the one cycle after an edge where ev_start_sent was 1 while start, interrupt enable and enable were all 1. It is 0 at all other times.
- R8: In master mode (ev_master=1), ev_stop_sent at an edge clears the stop bit, and this takes priority over a write in the same cycle.
- R9: In slave mode (ev_master=0), ev_stop_sent does not clear the stop bit. A write that would change the stop bit from 0 to 1 takes effect only if ev_byte_done is 1 in that cycle. A write that clears the stop bit always takes effect.
- R10: A write to the configuration address updates freq from data bits 2:0 and addr10 from data bit 3, but only while enabled is 0. While enabled, the write is ignored.
- R11: While disabled, ctl_gcall_en, ctl_start_req, ctl_ack_en, ctl_irq_en and ctl_stop_req are all 0. ctl_stop_req equals the stop bit ANDed with enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ev_start_sent | input | 1 | Engine has sent a start condition |
| ev_stop_sent | input | 1 | Engine has sent a stop condition |
| ev_byte_done | input | 1 | Byte transfer finished flag |
| ev_master | input | 1 | 1 = master mode, 0 = slave mode |
| ctl_enable | output | 1 | Peripheral enable |
| ctl_gcall_en | output | 1 | Acknowledge the general-call address |
| ctl_start_req | output | 1 | Start condition request |
| ctl_ack_en | output | 1 | Acknowledge received bytes |
| ctl_stop_req | output | 1 | Stop or release request |
| ctl_irq_en | output | 1 | Interrupt enable |
| irq_pulse | output | 1 | One-cycle interrupt on start sent |
| cfg_freq | output | FREQ_W | Clock-frequency code |
| cfg_addr10 | output | 1 | 10-bit addressing enable |

## Verification
The assertions make no assumption about how the engine event inputs are timed. They do assume that the register bus presents one address per cycle and that this address stays put while the cycle's outputs are observed. The stimulus keeps engine events as sparse one-cycle pulses. It holds the master/slave mode for long stretches, and it draws addresses mostly from the two mapped locations with an occasional unmapped one. This lets the slave-mode stop gating and the hardware-clear-versus-write collisions arise often. Directed sequences then cover the two-write enable, disable with stop held, and the configuration lock.

// File: rtl/i2c_ctl_pkg.sv
`timescale 1ns/1ps
package i2c_ctl_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic pe;
    logic engc;
    logic start;
    logic ack;
    logic stop;
    logic ite;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [DATA_W-1:0] ctl_pack(input ctl_t c);
    return {{(DATA_W-CTL_W){1'b0}}, c};
  endfunction

  function automatic logic stop_write_ok(input logic cur, input logic wbit,
                                         input logic master, input logic byte_done);
    return master || byte_done || !wbit || cur;
  endfunction

  function automatic ctl_t ctl_next(input ctl_t cur, input logic wr,
                                    input logic [DATA_W-1:0] wd,
                                    input logic start_clr, input logic stop_clr,
                                    input logic master, input logic byte_done);
    ctl_t n;
    n = cur;
    if (wr) begin
      if (!cur.pe) begin
        n.pe = wd[5];
      end else if (!wd[5]) begin
        n.pe = 1'b0;
      end else begin
        n.engc  = wd[4];
        n.start = wd[3];
        n.ack   = wd[2];
        n.ite   = wd[0];
        if (stop_write_ok(cur.stop, wd[1], master, byte_done)) n.stop = wd[1];
      end
    end
    if (start_clr) n.start = 1'b0;
    if (stop_clr)  n.stop  = 1'b0;
    if (!n.pe) begin
      n.engc  = 1'b0;
      n.start = 1'b0;
      n.ack   = 1'b0;
      n.ite   = 1'b0;
    end
    return n;
  endfunction
endpackage

// File: rtl/i2c_ctl_reg.sv
`timescale 1ns/1ps
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start_clr,
  input  logic              stop_clr,
  input  logic              master,
  input  logic              byte_done,
  output ctl_t              ctl_q
);
  ctl_t ctl_d;

  always_comb ctl_d = ctl_next(ctl_q, wr_en, wdata, start_clr, stop_clr, master, byte_done);

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/i2c_cfg_guard.sv
`timescale 1ns/1ps
module i2c_cfg_guard
  import i2c_ctl_pkg::*;
#(
  parameter int FREQ_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [FREQ_W-1:0] freq_q,
  output logic              addr10_q,
  output logic              wr_blocked
);
  logic wr_take;

  assign wr_take    = wr_req && !locked;
  assign wr_blocked = wr_req && locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q   <= '0;
      addr10_q <= 1'b0;
    end else if (wr_take) begin
      freq_q   <= wdata[FREQ_W-1:0];
      addr10_q <= wdata[FREQ_W];
    end
  end
endmodule

// File: rtl/i2c_ctl_irq.sv
`timescale 1ns/1ps
module i2c_ctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_done,
  input  logic start_pending,
  input  logic irq_enabled,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= start_done && start_pending && irq_enabled;
  end
endmodule

// File: rtl/i2c_ctl_regs.sv
`timescale 1ns/1ps
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CTL_ADDR = 0,
  parameter int CFG_ADDR = 1,
  parameter int FREQ_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_start_sent,
  input  logic              ev_stop_sent,
  input  logic              ev_byte_done,
  input  logic              ev_master,
  output logic              ctl_enable,
  output logic              ctl_gcall_en,
  output logic              ctl_start_req,
  output logic              ctl_ack_en,
  output logic              ctl_stop_req,
  output logic              ctl_irq_en,
  output logic              irq_pulse,
  output logic [FREQ_W-1:0] cfg_freq,
  output logic              cfg_addr10
);
  localparam int CFG_PAD = DATA_W - FREQ_W - 1;

  logic sel_ctl, sel_cfg;
  logic ctl_wr, cfg_wr;
  logic start_clr_ev, stop_clr_ev, cfg_wr_blocked;
  ctl_t ctl_q;

  assign sel_ctl      = (reg_addr == ADDR_W'(CTL_ADDR));
  assign sel_cfg      = (reg_addr == ADDR_W'(CFG_ADDR));
  assign ctl_wr       = reg_wr && sel_ctl;
  assign cfg_wr       = reg_wr && sel_cfg;
  assign start_clr_ev = ev_start_sent;
  assign stop_clr_ev  = ev_stop_sent && ev_master;

  i2c_ctl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr),
    .wdata     (reg_wdata),
    .start_clr (start_clr_ev),
    .stop_clr  (stop_clr_ev),
    .master    (ev_master),
    .byte_done (ev_byte_done),
    .ctl_q     (ctl_q)
  );

  i2c_cfg_guard #(.FREQ_W(FREQ_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (cfg_wr),
    .locked     (ctl_q.pe),
    .wdata      (reg_wdata),
    .freq_q     (cfg_freq),
    .addr10_q   (cfg_addr10),
    .wr_blocked (cfg_wr_blocked)
  );

  i2c_ctl_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_done    (start_clr_ev),
    .start_pending (ctl_q.start),
    .irq_enabled   (ctl_q.ite && ctl_q.pe),
    .irq_q         (irq_pulse)
  );

  assign ctl_enable    = ctl_q.pe;
  assign ctl_gcall_en  = ctl_q.engc;
  assign ctl_start_req = ctl_q.start;
  assign ctl_ack_en    = ctl_q.ack;
  assign ctl_stop_req  = ctl_q.stop && ctl_q.pe;
  assign ctl_irq_en    = ctl_q.ite;

  always_comb begin
    if (sel_ctl)      reg_rdata = ctl_pack(ctl_q);
    else if (sel_cfg) reg_rdata = {{CFG_PAD{1'b0}}, cfg_addr10, cfg_freq};
    else              reg_rdata = '0;
  end
endmodule

// File: rtl/i2c_ctl_regs_chk.sv
`timescale 1ns/1ps
module i2c_ctl_regs_chk #(
  parameter int ADDR_W   = 2,
  parameter int CTL_ADDR = 0,
  parameter int FREQ_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_rdata,
  input logic              ev_start_sent,
  input logic              ev_stop_sent,
  input logic              ev_master,
  input logic              ctl_enable,
  input logic              ctl_gcall_en,
  input logic              ctl_start_req,
  input logic              ctl_ack_en,
  input logic              ctl_stop_req,
  input logic              ctl_irq_en,
  input logic              irq_pulse,
  input logic [FREQ_W-1:0] cfg_freq,
  input logic              cfg_addr10,
  input logic              cfg_wr_blocked
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTL_ADDR)) |-> (reg_rdata[7:6] == 2'b00)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> !(ctl_gcall_en || ctl_start_req || ctl_ack_en || ctl_irq_en || ctl_stop_req)); // R11
  AST_FIRST_WRITE_PE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTL_ADDR) && !ctl_enable)
      |=> !(ctl_gcall_en || ctl_start_req || ctl_ack_en || ctl_irq_en)); // R2
  AST_START_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_sent |=> !ctl_start_req); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ev_start_sent && ctl_start_req && ctl_irq_en)); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R7
  AST_MASTER_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_sent && ev_master) |=> !ctl_stop_req); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enable |=> ($stable(cfg_freq) && $stable(cfg_addr10))); // R10
  AST_CFG_BLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_blocked |-> ctl_enable); // R10
endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .FREQ_W(FREQ_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_addr       (reg_addr),
  .reg_wr         (reg_wr),
  .reg_rdata      (reg_rdata),
  .ev_start_sent  (ev_start_sent),
  .ev_stop_sent   (ev_stop_sent),
  .ev_master      (ev_master),
  .ctl_enable     (ctl_enable),
  .ctl_gcall_en   (ctl_gcall_en),
  .ctl_start_req  (ctl_start_req),
  .ctl_ack_en     (ctl_ack_en),
  .ctl_stop_req   (ctl_stop_req),
  .ctl_irq_en     (ctl_irq_en),
  .irq_pulse      (irq_pulse),
  .cfg_freq       (cfg_freq),
  .cfg_addr10     (cfg_addr10),
  .cfg_wr_blocked (cfg_wr_blocked)
);

// File: tb/i2c_ctl_regs_bench.sv
`timescale 1ns/1ps
module i2c_ctl_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ev_start_sent = 1'b0, ev_stop_sent = 1'b0, ev_byte_done = 1'b0, ev_master = 1'b0;
  logic       ctl_enable, ctl_gcall_en, ctl_start_req, ctl_ack_en, ctl_stop_req, ctl_irq_en;
  logic       irq_pulse;
  logic [2:0] cfg_freq;
  logic       cfg_addr10;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  bit m_pe, m_gc, m_st, m_ak, m_sp, m_ie, m_irq, m_a10;
  bit [2:0] m_fq;

  always #2 clk = ~clk;

  i2c_ctl_regs u_i2c_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_start_sent(ev_start_sent), .ev_stop_sent(ev_stop_sent),
    .ev_byte_done(ev_byte_done), .ev_master(ev_master),
    .ctl_enable(ctl_enable), .ctl_gcall_en(ctl_gcall_en),
    .ctl_start_req(ctl_start_req), .ctl_ack_en(ctl_ack_en),
    .ctl_stop_req(ctl_stop_req), .ctl_irq_en(ctl_irq_en),
    .irq_pulse(irq_pulse), .cfg_freq(cfg_freq), .cfg_addr10(cfg_addr10)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_pe, m_gc, m_st, m_ak, m_sp, m_ie};
      2'd1:    return {4'b0000, m_a10, m_fq};
      default: return 8'h00;
    endcase
  endfunction

  // Advance the model by one edge, from the requirements
  task automatic model_edge(input logic [1:0] a, input bit w, input logic [7:0] d,
                            input bit ss, input bit sp, input bit bd, input bit ms);
    bit n_pe = m_pe, n_gc = m_gc, n_st = m_st, n_ak = m_ak, n_sp = m_sp, n_ie = m_ie;
    m_irq = ss && m_st && m_ie && m_pe;                  // R7
    if (w && a == 2'd1 && !m_pe) begin                   // R10
      m_fq  = d[2:0];
      m_a10 = d[3];
    end
    if (w && a == 2'd0) begin
      if (!m_pe) n_pe = d[5];                            // R2
      else if (!d[5]) n_pe = 0;                          // R4
      else begin                                         // R3
        n_gc = d[4]; n_st = d[3]; n_ak = d[2]; n_ie = d[0];
        if (ms || bd || !d[1] || m_sp) n_sp = d[1];      // R9
      end
    end
    if (ss) n_st = 0;                                    // R6
    if (sp && ms) n_sp = 0;                              // R8
    if (!n_pe) begin n_gc = 0; n_st = 0; n_ak = 0; n_ie = 0; end
    m_pe = n_pe; m_gc = n_gc; m_st = n_st; m_ak = n_ak; m_sp = n_sp; m_ie = n_ie;
  endtask

  task automatic compare_all(input logic [1:0] a);
    check("R5 rdata", reg_rdata, exp_read(a));
    check("R3 enable", {7'd0, ctl_enable}, {7'd0, m_pe});
    check("R3 gcall", {7'd0, ctl_gcall_en}, {7'd0, m_gc});
    check("R6 start", {7'd0, ctl_start_req}, {7'd0, m_st});
    check("R3 ack", {7'd0, ctl_ack_en}, {7'd0, m_ak});
    check("R11 stop_req", {7'd0, ctl_stop_req}, {7'd0, m_sp && m_pe});
    check("R3 irq_en", {7'd0, ctl_irq_en}, {7'd0, m_ie});
    check("R7 irq", {7'd0, irq_pulse}, {7'd0, m_irq});
    check("R10 cfg", {4'd0, cfg_addr10, cfg_freq}, {4'd0, m_a10, m_fq});
  endtask

  task automatic step(input logic [1:0] a, input bit w, input logic [7:0] d,
                      input bit ss, input bit sp, input bit bd, input bit ms);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d;
    ev_start_sent = ss; ev_stop_sent = sp; ev_byte_done = bd; ev_master = ms;
    @(posedge clk);
    model_edge(a, w, d, ss, sp, bd, ms);
    #1;
    compare_all(a);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 ctl", reg_rdata, 8'h00);
    check("R1 outs", {2'd0, ctl_enable, ctl_gcall_en, ctl_start_req, ctl_ack_en, ctl_stop_req, irq_pulse}, 8'h00);
    step(2'd1, 0, 8'h00, 0, 0, 0, 0);
    check("R1 cfg", reg_rdata, 8'h00);

    // R10 config write while disabled
    step(2'd1, 1, 8'hFD, 0, 0, 0, 0);
    check("R10 cfg load", reg_rdata, 8'h0D);
    // R2 first write sets only PE
    step(2'd0, 1, 8'hFF, 0, 0, 0, 0);
    check("R2 first write", reg_rdata, 8'h20);
    // R9 slave, byte not done: stop set refused
    step(2'd0, 1, 8'h3F, 0, 0, 0, 0);
    check("R9 stop refused", reg_rdata, 8'h3D);
    // R9 slave with byte done: stop accepted
    step(2'd0, 1, 8'h3F, 0, 0, 1, 0);
    check("R9 stop accepted", reg_rdata, 8'h3F);
    // R9 slave stop_sent does not clear
    step(2'd0, 0, 8'h00, 0, 1, 0, 0);
    check("R9 stop kept", {7'd0, ctl_stop_req}, 8'h01);
    // R10 config locked while enabled
    step(2'd1, 1, 8'h02, 0, 0, 0, 0);
    check("R10 cfg locked", reg_rdata, 8'h0D);
    // R6/R7 start sent collides with write setting start
    step(2'd0, 1, 8'h3D, 1, 0, 0, 1);
    check("R6 start clr wins", {7'd0, ctl_start_req}, 8'h00);
    check("R7 irq pulse", {7'd0, irq_pulse}, 8'h01);
    step(2'd0, 0, 8'h00, 0, 0, 0, 1);
    check("R7 irq one cycle", {7'd0, irq_pulse}, 8'h00);
    // R8 master stop sent beats write
    step(2'd0, 1, 8'h3E, 0, 1, 0, 1);
    check("R8 stop clr wins", reg_rdata, 8'h3C);
    step(2'd0, 1, 8'h3E, 0, 0, 0, 1);
    // R4 disable keeps stop
    step(2'd0, 1, 8'h00, 0, 0, 0, 1);
    check("R4 disable keeps stop", reg_rdata, 8'h02);
    check("R11 stop_req gated", {7'd0, ctl_stop_req}, 8'h00);
    // R5 unmapped address
    step(2'd3, 1, 8'hFF, 0, 0, 0, 0);
    check("R5 unmapped", reg_rdata, 8'h00);

    // constrained random
    void'($urandom(32'h1C2B));
    begin
      bit ms = 0;
      for (int i = 0; i < 6000; i++) begin
        logic [1:0] a;
        logic [7:0] d;
        if ($urandom_range(63) == 0) ms = ~ms;
        a = ($urandom_range(15) == 0) ? 2'd2 + 2'($urandom_range(1)) : 2'($urandom_range(1));
        d = 8'($urandom);
        if ($urandom_range(3) == 0) d[5] = 1'b1;
        step(a, $urandom_range(2) == 0, d,
             $urandom_range(5) == 0, $urandom_range(7) == 0,
             $urandom_range(2) == 0, ms);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule